// File: doc/BRIEF.md
# DMA Channel Command and Status Unit

This block holds the control and status registers of one DMA channel and turns software commands into single-cycle requests for a separate transfer engine. Software reaches it through a 16-bit register port made of three byte pairs: a status byte with an error-code byte, a device-mode byte with an operation byte, and a sequence byte with a command byte. Writing ones into the command byte requests start, abort, pause or resume. The unit keeps the flags that report whether the channel is running, has finished or was aborted.

The running state of the channel is the active bit in the status byte, and no other flag holds it. Status flags are cleared by writing ones, and the active bit and the live peripheral-line bit are protected from that. When the device-mode byte selects burst operation, the unit raises a hold request to the CPU for as long as the burst runs. The transfer engine reports the end of a transfer with a one-cycle strobe. All registered effects of a write or a strobe appear after the clock edge that samples them.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register pair reads 0x0000 (with the peripheral line low), `cpu_hold` is low and no command pulse is high.
- R2: Pair 1 reads {device-mode byte, operation byte} and pair 2 reads {sequence byte, command byte}. Each byte lane is written only when its enable is set: `reg_be[1]` selects bits 15:8 and `reg_be[0]` selects bits 7:0. Pair 3 reads zero.
- R3: Writing a command byte with bit 7 set, and bit 4 clear, clears status bits 7:4 and sets status bit 3 (active). It also gives `go_pulse`. All of these appear after the sampling edge.
- R4: Pair 0 reads {status, error code}. A write to the status byte clears each status bit whose written value is 1, limited to the mask 0xF6. The active bit 3 is never cleared this way. Status bit 0 always mirrors `periph_flag`.
- R5: Command bit 4 aborts the channel when it is active. The abort sets status bits 7 and 4, clears the active bit, loads the error code 0x11 and gives `stop_pulse`. On an idle channel, command bit 4 changes nothing and gives no pulse.
- R6: When command bits 7 and 4 are written together, the abort takes effect and no `go_pulse` is given.
- R7: A `xfer_done` strobe while the channel is active sets status bits 7:5, clears the active bit and clears bits 7:6 of the stored command byte. A strobe while the channel is idle is ignored.
- R8: If the device-mode bits 15:14 of pair 1 are 00 at start, `cpu_hold` rises with the start and falls with the completion or the abort. With any other value, `cpu_hold` stays low.
- R9: Command bit 5 pauses an active channel with `pause_pulse` and sets the internal paused flag. Command bit 6 gives `resume_pulse` and clears that flag only while the channel is paused. Command bit 5 on an idle channel, and bit 6 on a channel that is not paused, give no pulse.
- R10: Each command pulse is high for exactly one cycle per accepted command.
- R11: If `xfer_done` and an abort command arrive in the same cycle on an active channel, the completion takes effect and the abort is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register pair select, used for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_be | input | 2 | Byte-lane enables, bit 1 for the high byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected pair, combinational |
| xfer_done | input | 1 | Completion strobe from the transfer engine |
| periph_flag | input | 1 | Live peripheral line shown in status bit 0 |
| go_pulse | output | 1 | Start request to the engine |
| stop_pulse | output | 1 | Abort request to the engine |
| pause_pulse | output | 1 | Pause request to the engine |
| resume_pulse | output | 1 | Resume request to the engine |
| cpu_hold | output | 1 | CPU hold request during a burst |

## Verification
The hardest cases to reach are collisions inside one cycle: a command write that arrives together with the engine's completion strobe, and a command byte that carries both start and abort. The stimulus table sets up an active channel first and then drives those combinations on the same edge. It then reads back status, error code and command byte to see which action won. The paused flag has no read path, so it is observed through the resume pulse: a second resume must give nothing.

// File: rtl/dma_cc_pkg.sv
// Package: shared widths, register pair codes, bit positions and masks
// for the DMA channel command/status unit. Assumes 8-bit byte lanes.
package dma_cc_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 2;
    localparam int LANES  = REG_W / BYTE_W;

    typedef enum logic [ADDR_W-1:0] {
        PAIR_STAT = 2'd0,
        PAIR_MODE = 2'd1,
        PAIR_SEQ  = 2'd2,
        PAIR_NONE = 2'd3
    } pair_e;

    // Status byte bit positions
    localparam int ST_ACT    = 3;
    localparam int ST_PERIPH = 0;

    // Command byte bit positions
    localparam int CC_GO     = 7;
    localparam int CC_RESUME = 6;
    localparam int CC_PAUSE  = 5;
    localparam int CC_STOP   = 4;

    localparam logic [BYTE_W-1:0] ACT_MASK   = 8'h08;
    localparam logic [BYTE_W-1:0] W1C_MASK   = 8'hF6;
    localparam logic [BYTE_W-1:0] STORE_MASK = 8'hF8;
    localparam logic [BYTE_W-1:0] STOP_SET   = 8'h90;
    localparam logic [BYTE_W-1:0] DONE_SET   = 8'hE0;
    localparam logic [BYTE_W-1:0] GO_CLEAR   = 8'hF0;
    localparam logic [BYTE_W-1:0] ERR_STOP   = 8'h11;
endpackage

// File: rtl/dma_cc_cmd.sv
// Command decoder: turns a register write into a status write strobe
// and raw command requests taken from the low byte of the sequence pair.
// Assumes reg_be[0] is the low byte lane and reg_be[1] the high one.
module dma_cc_cmd
    import dma_cc_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic [BYTE_W-1:0] cc_byte,
    output logic              stat_wr,
    output logic              req_go,
    output logic              req_stop,
    output logic              req_pause,
    output logic              req_resume
);
    logic cc_wr;

    // Decode which byte of which pair this write targets
    always_comb begin
        stat_wr = wr && (addr == PAIR_STAT) && be[LANES-1];
        cc_wr   = wr && (addr == PAIR_SEQ) && be[0];
    end

    // Raw command requests, before any state qualification
    always_comb begin
        req_go     = cc_wr && cc_byte[CC_GO];
        req_stop   = cc_wr && cc_byte[CC_STOP];
        req_pause  = cc_wr && cc_byte[CC_PAUSE];
        req_resume = cc_wr && cc_byte[CC_RESUME];
    end
endmodule

// File: rtl/dma_cc_status.sv
// Status engine: qualifies the command requests against the channel state,
// holds the status byte, the error code, the paused flag and the CPU hold,
// and issues registered one-cycle command pulses. Order of effects in a cycle:
// clear-by-one write, then completion, then abort, then start (later wins).
module dma_cc_status
    import dma_cc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ERR_CODE = ERR_STOP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [BYTE_W-1:0] clr_bits,
    input  logic              req_go,
    input  logic              req_stop,
    input  logic              req_pause,
    input  logic              req_resume,
    input  logic              done_in,
    input  logic              burst_mode,
    output logic [BYTE_W-1:0] stat_q,
    output logic [BYTE_W-1:0] err_q,
    output logic              halted_q,
    output logic              hold_q,
    output logic              done_take,
    output logic              go_p,
    output logic              stop_p,
    output logic              pause_p,
    output logic              resume_p
);
    logic              act;
    logic              stop_take;
    logic              go_take;
    logic              pause_take;
    logic              resume_take;
    logic [BYTE_W-1:0] stat_d;
    logic [BYTE_W-1:0] err_d;
    logic              halted_d;
    logic              hold_d;

    // Decide which commands are accepted in this cycle
    always_comb begin
        act         = stat_q[ST_ACT];
        done_take   = done_in && act;
        stop_take   = req_stop && act && !done_take;
        go_take     = req_go && !req_stop;
        pause_take  = req_pause && act && !done_take && !stop_take && !go_take;
        resume_take = req_resume && halted_q && !pause_take && !done_take && !stop_take;
    end

    // Next status byte and error code
    always_comb begin
        stat_d = stat_q;
        if (stat_wr)
            stat_d = stat_d & ~(clr_bits & W1C_MASK);
        if (done_take)
            stat_d = (stat_d | DONE_SET) & ~ACT_MASK;
        if (stop_take)
            stat_d = (stat_d | STOP_SET) & ~ACT_MASK;
        if (go_take)
            stat_d = (stat_d & ~GO_CLEAR) | ACT_MASK;
        stat_d = stat_d & STORE_MASK;
        err_d  = stop_take ? ERR_CODE : err_q;
    end

    // Next paused flag and CPU hold request
    always_comb begin
        halted_d = halted_q;
        if (resume_take || done_take || stop_take || go_take)
            halted_d = 1'b0;
        if (pause_take)
            halted_d = 1'b1;
        hold_d = hold_q;
        if (done_take || stop_take)
            hold_d = 1'b0;
        if (go_take)
            hold_d = burst_mode;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            err_q    <= '0;
            halted_q <= 1'b0;
            hold_q   <= 1'b0;
        end else begin
            stat_q   <= stat_d;
            err_q    <= err_d;
            halted_q <= halted_d;
            hold_q   <= hold_d;
        end
    end

    // One-cycle command pulses toward the transfer engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_p     <= 1'b0;
            stop_p   <= 1'b0;
            pause_p  <= 1'b0;
            resume_p <= 1'b0;
        end else begin
            go_p     <= go_take;
            stop_p   <= stop_take;
            pause_p  <= pause_take;
            resume_p <= resume_take;
        end
    end
endmodule

// File: rtl/dma_cc_regs.sv
// Plain control storage: the mode pair (device-mode, operation) and the
// sequence pair (sequence, command), one byte register per lane. The
// stored command byte loses bits 7:6 when the channel completes.
module dma_cc_regs
    import dma_cc_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [LANES-1:0]                 be,
    input  logic [REG_W-1:0]                 wdata,
    input  logic                             done_take,
    output logic [1:0][REG_W-1:0]            words
);
    localparam int NPAIR = 2;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam bit IS_CC = (p == NPAIR - 1) && (l == 0);
            logic [BYTE_W-1:0] q;
            logic              hit;

            // Lane write select for this pair
            always_comb hit = wr && (addr == ADDR_W'(p + 1)) && be[l];

            // Byte storage, with completion clearing start/resume bits of the command byte
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else begin
                    if (hit)
                        q <= wdata[l*BYTE_W +: BYTE_W];
                    if (IS_CC && done_take)
                        q[BYTE_W-1 -: 2] <= 2'b00;
                end
            end

            assign words[p][l*BYTE_W +: BYTE_W] = q;
        end
    end
endmodule

// File: rtl/dma_chan_ctrl.sv
// Top: DMA channel command/status unit. Wires the decoder, status engine
// and control storage, and muxes the selected register pair onto the read
// port. Assumes a single clock and a synchronous active-low reset.
module dma_chan_ctrl
    import dma_cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [LANES-1:0]  reg_be,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              xfer_done,
    input  logic              periph_flag,
    output logic              go_pulse,
    output logic              stop_pulse,
    output logic              pause_pulse,
    output logic              resume_pulse,
    output logic              cpu_hold
);
    logic                  stat_wr;
    logic                  req_go;
    logic                  req_stop;
    logic                  req_pause;
    logic                  req_resume;
    logic                  done_take;
    logic [BYTE_W-1:0]     stat_q;
    logic [BYTE_W-1:0]     err_q;
    logic                  halted_q;
    logic                  chan_active;
    logic                  burst_mode;
    logic [1:0][REG_W-1:0] words;

    dma_cc_cmd u_cmd (
        .wr         (reg_wr),
        .addr       (reg_addr),
        .be         (reg_be),
        .cc_byte    (reg_wdata[BYTE_W-1:0]),
        .stat_wr    (stat_wr),
        .req_go     (req_go),
        .req_stop   (req_stop),
        .req_pause  (req_pause),
        .req_resume (req_resume)
    );

    dma_cc_status #(.ERR_CODE(ERR_STOP)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_wr    (stat_wr),
        .clr_bits   (reg_wdata[REG_W-1:BYTE_W]),
        .req_go     (req_go),
        .req_stop   (req_stop),
        .req_pause  (req_pause),
        .req_resume (req_resume),
        .done_in    (xfer_done),
        .burst_mode (burst_mode),
        .stat_q     (stat_q),
        .err_q      (err_q),
        .halted_q   (halted_q),
        .hold_q     (cpu_hold),
        .done_take  (done_take),
        .go_p       (go_pulse),
        .stop_p     (stop_pulse),
        .pause_p    (pause_pulse),
        .resume_p   (resume_pulse)
    );

    dma_cc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .done_take (done_take),
        .words     (words)
    );

    // Channel state views used by the mode decode and the checker
    always_comb begin
        chan_active = stat_q[ST_ACT];
        burst_mode  = (words[0][REG_W-1 -: 2] == 2'b00);
    end

    // Read mux over the register pairs
    always_comb begin
        case (reg_addr)
            PAIR_STAT: reg_rdata = {stat_q | (BYTE_W'(periph_flag) << ST_PERIPH), err_q};
            PAIR_MODE: reg_rdata = words[0];
            PAIR_SEQ:  reg_rdata = words[1];
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
// Checker: temporal properties of the command pulses, channel state,
// error code and CPU hold. Attached to the top module by bind.
module dma_chan_ctrl_chk #(
    parameter logic [7:0] ERR_CODE = 8'h11
) (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       stop,
    input logic       pause,
    input logic       resume,
    input logic       active,
    input logic       halted,
    input logic       hold,
    input logic [7:0] err
);
    assert_go_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> active);

    assert_stop_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop |-> (!active && err == ERR_CODE));

    assert_stop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && stop));

    assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !hold);

    assert_hold_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> active);

    assert_pause_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> halted);

    assert_resume_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |-> !halted);

    assert_go_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    assert_resume_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    assert_one_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go, stop, pause, resume}));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.ERR_CODE(8'h11)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go_pulse),
    .stop   (stop_pulse),
    .pause  (pause_pulse),
    .resume (resume_pulse),
    .active (chan_active),
    .halted (halted_q),
    .hold   (cpu_hold),
    .err    (err_q)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
    localparam int CLK_P = 10;
    localparam int NVEC  = 19;

    typedef struct packed {
        logic        we;
        logic [1:0]  addr;
        logic [1:0]  be;
        logic [15:0] wdata;
        logic        done;
        logic [1:0]  raddr;
        logic [15:0] exp_rd;
        logic [3:0]  exp_p;    // {go, stop, pause, resume}
        logic        exp_hold;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd1, 2'd3, 16'h0000, 1'b0, 2'd1, 16'h0000, 4'b0000, 1'b0, 8'd2},  // R2 burst mode, op 0
        '{1'b1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 16'h0800, 4'b1000, 1'b1, 8'd3},  // R3 start, R8 hold
        '{1'b1, 2'd2, 2'd1, 16'h0020, 1'b0, 2'd0, 16'h0800, 4'b0010, 1'b1, 8'd9},  // R9 pause
        '{1'b1, 2'd2, 2'd1, 16'h0040, 1'b0, 2'd0, 16'h0800, 4'b0001, 1'b1, 8'd9},  // R9 resume
        '{1'b1, 2'd2, 2'd1, 16'h0040, 1'b0, 2'd0, 16'h0800, 4'b0000, 1'b1, 8'd9},  // R9 resume not paused
        '{1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd2, 16'h0000, 4'b0000, 1'b0, 8'd7},  // R7 done clears cmd 7:6
        '{1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'hE000, 4'b0000, 1'b0, 8'd7},  // R7 done status
        '{1'b1, 2'd0, 2'd2, 16'hFF00, 1'b0, 2'd0, 16'h0000, 4'b0000, 1'b0, 8'd4},  // R4 clear by ones
        '{1'b1, 2'd1, 2'd2, 16'h4000, 1'b0, 2'd1, 16'h4000, 4'b0000, 1'b0, 8'd2},  // R2 high lane only
        '{1'b1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 16'h0800, 4'b1000, 1'b0, 8'd8},  // R8 no hold off burst
        '{1'b1, 2'd0, 2'd2, 16'hFF00, 1'b0, 2'd0, 16'h0800, 4'b0000, 1'b0, 8'd4},  // R4 active protected
        '{1'b1, 2'd2, 2'd1, 16'h0090, 1'b0, 2'd0, 16'h9011, 4'b0100, 1'b0, 8'd6},  // R6 abort beats start
        '{1'b1, 2'd2, 2'd1, 16'h0010, 1'b0, 2'd0, 16'h9011, 4'b0000, 1'b0, 8'd5},  // R5 abort when idle
        '{1'b0, 2'd0, 2'd0, 16'h0000, 1'b1, 2'd0, 16'h9011, 4'b0000, 1'b0, 8'd7},  // R7 done when idle
        '{1'b1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 16'h0811, 4'b1000, 1'b0, 8'd3},  // R3 start clears 7:4
        '{1'b1, 2'd2, 2'd1, 16'h0010, 1'b1, 2'd0, 16'hE011, 4'b0000, 1'b0, 8'd11}, // R11 done beats abort
        '{1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd2, 16'h0010, 4'b0000, 1'b0, 8'd7},  // R7 cmd byte kept 0x10
        '{1'b1, 2'd2, 2'd3, 16'hA500, 1'b0, 2'd2, 16'hA500, 4'b0000, 1'b0, 8'd2},  // R2 sequence pair
        '{1'b1, 2'd2, 2'd1, 16'h0020, 1'b0, 2'd2, 16'hA520, 4'b0000, 1'b0, 8'd9}   // R9 pause when idle
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        xfer_done = 1'b0;
    logic        periph_flag = 1'b0;
    logic        go_pulse, stop_pulse, pause_pulse, resume_pulse, cpu_hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_chan_ctrl i_dma_chan_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_be       (reg_be),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .xfer_done    (xfer_done),
        .periph_flag  (periph_flag),
        .go_pulse     (go_pulse),
        .stop_pulse   (stop_pulse),
        .pause_pulse  (pause_pulse),
        .resume_pulse (resume_pulse),
        .cpu_hold     (cpu_hold)
    );

    task automatic check(input string tag, input logic [15:0] exp_rd,
                         input logic [3:0] exp_p, input logic exp_hold);
        logic [3:0] act_p;
        act_p = {go_pulse, stop_pulse, pause_pulse, resume_pulse};
        checks++;
        if (reg_rdata !== exp_rd || act_p !== exp_p || cpu_hold !== exp_hold) begin
            errors++;
            $display("FAIL %s rd=%h p=%b hold=%b expected rd=%h p=%b hold=%b",
                     tag, reg_rdata, act_p, cpu_hold, exp_rd, exp_p, exp_hold);
        end
    endtask

    // One cycle of stimulus, then read-back and check in the following cycle
    task automatic step(input logic we, input logic [1:0] addr, input logic [1:0] be,
                        input logic [15:0] wdata, input logic done, input logic [1:0] raddr,
                        input logic [15:0] exp_rd, input logic [3:0] exp_p,
                        input logic exp_hold, input string tag);
        @(negedge clk);
        reg_wr = we; reg_addr = addr; reg_be = be; reg_wdata = wdata; xfer_done = done;
        @(posedge clk);
        #1;
        reg_wr = 1'b0; xfer_done = 1'b0; reg_addr = raddr;
        #1;
        check(tag, exp_rd, exp_p, exp_hold);
    endtask

    task automatic peek(input logic [1:0] raddr, input logic [15:0] exp_rd,
                        input logic [3:0] exp_p, input logic exp_hold, input string tag);
        reg_addr = raddr;
        #1;
        check(tag, exp_rd, exp_p, exp_hold);
    endtask

    initial begin
        #(CLK_P * 5000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state of every pair
        peek(2'd0, 16'h0000, 4'b0000, 1'b0, "R1 stat");
        peek(2'd1, 16'h0000, 4'b0000, 1'b0, "R1 mode");
        peek(2'd2, 16'h0000, 4'b0000, 1'b0, "R1 seq");
        peek(2'd3, 16'h0000, 4'b0000, 1'b0, "R2 pair3");

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wdata, VEC[i].done,
                 VEC[i].raddr, VEC[i].exp_rd, VEC[i].exp_p, VEC[i].exp_hold,
                 $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R4: peripheral bit is live and survives a clear-by-ones write
        periph_flag = 1'b1;
        peek(2'd0, 16'hE111, 4'b0000, 1'b0, "R4 periph live");
        step(1'b1, 2'd0, 2'd2, 16'hFF00, 1'b0, 2'd0, 16'h0111, 4'b0000, 1'b0, "R4 periph kept");
        periph_flag = 1'b0;

        // R8: burst start then abort releases the hold; R10 pulse lasts one cycle
        step(1'b1, 2'd1, 2'd2, 16'h0000, 1'b0, 2'd1, 16'h0000, 4'b0000, 1'b0, "R8 burst mode");
        step(1'b1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 16'h0811, 4'b1000, 1'b1, "R8 hold on");
        step(1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h0811, 4'b0000, 1'b1, "R10 go one cycle");
        step(1'b1, 2'd2, 2'd1, 16'h0010, 1'b0, 2'd0, 16'h9011, 4'b0100, 1'b0, "R8 hold off on abort");
        step(1'b0, 2'd0, 2'd0, 16'h0000, 1'b0, 2'd0, 16'h9011, 4'b0000, 1'b0, "R10 stop one cycle");

        // R1: reset while a burst is running
        step(1'b1, 2'd2, 2'd1, 16'h0080, 1'b0, 2'd0, 16'h0811, 4'b1000, 1'b1, "R8 hold again");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        peek(2'd0, 16'h0000, 4'b0000, 1'b0, "R1 stat after reset");
        peek(2'd2, 16'h0000, 4'b0000, 1'b0, "R1 seq after reset");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule